// File: doc/BRIEF.md
# Speed-Tracking Automatic Gear Selector

This block keeps a vehicle speed value in whole mph and picks a gear from it. A single direction input asks for one step of change: high means accelerate, which adds one mph, and low means brake, which removes one mph. A small datapath holds the speed in a saturating up/down register. A comparator tests the speed against a fixed 75 mph shift point and hands a "below threshold" flag to a two-bit controller. The controller drives the gear output and an indicator light that is lit in high gear only.

The controller runs in two phases. In an update phase the speed register takes one step. In the following check phase the speed holds, and the controller reads the comparator flag to choose the gear for the next pair of cycles. The speed therefore changes on every second clock edge. The gear and the light change on the edge that comes directly after the speed step that caused the change.

There are four controller states, encoded {gear bit, phase bit}:
- `LOW_UPD` (00): low gear, speed steps.
- `LOW_CHK` (01): low gear, speed holds.
- `HIGH_UPD` (10): high gear, speed steps.
- `HIGH_CHK` (11): high gear, speed holds.

There are six transitions:
- `LOW_UPD`→`LOW_CHK` (always).
- `HIGH_UPD`→`HIGH_CHK` (always).
- `LOW_CHK`→`LOW_UPD` and `HIGH_CHK`→`LOW_UPD` when the speed is below 75 (downshift or stay low).
- `LOW_CHK`→`HIGH_UPD` and `HIGH_CHK`→`HIGH_UPD` when the speed is 75 or more (upshift or stay high).

Top module: `gear_selector`

## Requirements
- R1: While `rst_n` is low and after it is released, speed is 0, `gear_high` is 0, `light` is 0, and the controller is in `LOW_UPD`.
- R2: The controller alternates strictly between an update state and a check state. The first edge after reset leaves an update state.
- R3: On an edge that leaves an update state with `accel`=1, speed rises by 1. At 255 it stays at 255.
- R4: On an edge that leaves an update state with `accel`=0, speed falls by 1. At 0 it stays at 0.
- R5: On an edge that leaves a check state, speed does not change, whatever the value of `accel`.
- R6: On an edge that leaves a check state with speed below 75, `gear_high` becomes 0.
- R7: On an edge that leaves a check state with speed of 75 or more (75 included), `gear_high` becomes 1.
- R8: On an edge that leaves an update state, `gear_high` keeps its value.
- R9: `light` equals `gear_high` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| accel | input | 1 | 1 = accelerate one step, 0 = brake one step |
| speed | output | 8 | Current speed in mph |
| gear_high | output | 1 | 1 = high gear, 0 = low gear |
| light | output | 1 | High-gear indicator lamp |

## Verification
Each speed step appears one edge after `accel` is applied in an update phase. The gear result for that new speed appears on the very next edge, when the controller leaves the check phase. The bench drives `accel` at a falling edge and crosses exactly one rising edge. It advances its own model of the speed, the phase and the gear across that edge, and compares at the next falling edge, so every check lands in the single cycle in which a result is due.

The stimulus includes:
- Steps through 74, 75 and back, to cover the shift point.
- Runs into both saturation limits.
- A reversed `accel` during check phases.
- A random walk around the shift point.

// File: rtl/gsel_pkg.sv
package gsel_pkg;

    typedef enum logic [1:0] {
        LOW_UPD  = 2'b00,
        LOW_CHK  = 2'b01,
        HIGH_UPD = 2'b10,
        HIGH_CHK = 2'b11
    } gsel_state_t;

endpackage

// File: rtl/gsel_speed_reg.sv
module gsel_speed_reg #(
    parameter int SPEED_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step_en,
    input  logic               step_up,
    output logic [SPEED_W-1:0] speed_q
);
    localparam logic [SPEED_W-1:0] SPEED_MAX = {SPEED_W{1'b1}};
    localparam logic [SPEED_W-1:0] SPEED_MIN = '0;
    localparam logic [SPEED_W-1:0] ONE       = {{(SPEED_W-1){1'b0}}, 1'b1};

    logic [SPEED_W-1:0] speed_d;
    logic               at_top;
    logic               at_floor;

    assign at_top   = (speed_q == SPEED_MAX);
    assign at_floor = (speed_q == SPEED_MIN);

    always_comb begin
        speed_d = speed_q;
        if (step_en) begin
            if (step_up && !at_top) begin
                speed_d = speed_q + ONE;
            end else if (!step_up && !at_floor) begin
                speed_d = speed_q - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_q <= SPEED_MIN;
        end else begin
            speed_q <= speed_d;
        end
    end
endmodule

// File: rtl/gsel_cmp.sv
module gsel_cmp #(
    parameter int SPEED_W   = 8,
    parameter int SHIFT_MPH = 75
) (
    input  logic [SPEED_W-1:0] speed_q,
    output logic               below
);
    localparam logic [SPEED_W-1:0] LIMIT = SPEED_W'(SHIFT_MPH);

    assign below = (speed_q < LIMIT);
endmodule

// File: rtl/gsel_ctrl.sv
module gsel_ctrl
    import gsel_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic below,
    output logic step_en,
    output logic gear_high,
    output logic light,
    output logic in_chk
);
    gsel_state_t state_q;
    gsel_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LOW_UPD:  state_d = LOW_CHK;
            HIGH_UPD: state_d = HIGH_CHK;
            LOW_CHK:  state_d = below ? LOW_UPD : HIGH_UPD;
            HIGH_CHK: state_d = below ? LOW_UPD : HIGH_UPD;
            default:  state_d = LOW_UPD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LOW_UPD;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        step_en   = 1'b0;
        gear_high = 1'b0;
        light     = 1'b0;
        in_chk    = 1'b0;
        unique case (state_q)
            LOW_UPD: begin
                step_en = 1'b1;
            end
            LOW_CHK: begin
                in_chk = 1'b1;
            end
            HIGH_UPD: begin
                step_en   = 1'b1;
                gear_high = 1'b1;
                light     = 1'b1;
            end
            HIGH_CHK: begin
                in_chk    = 1'b1;
                gear_high = 1'b1;
                light     = 1'b1;
            end
            default: begin
                step_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/gear_selector.sv
module gear_selector #(
    parameter int SPEED_W   = 8,
    parameter int SHIFT_MPH = 75
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accel,
    output logic [SPEED_W-1:0] speed,
    output logic               gear_high,
    output logic               light
);
    logic step_en;
    logic below;
    logic ctrl_chk;

    gsel_speed_reg #(.SPEED_W(SPEED_W)) u_speed (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .step_up (accel),
        .speed_q (speed)
    );

    gsel_cmp #(.SPEED_W(SPEED_W), .SHIFT_MPH(SHIFT_MPH)) u_cmp (
        .speed_q (speed),
        .below   (below)
    );

    gsel_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .below     (below),
        .step_en   (step_en),
        .gear_high (gear_high),
        .light     (light),
        .in_chk    (ctrl_chk)
    );
endmodule

// File: rtl/gear_selector_chk.sv
module gear_selector_chk #(
    parameter int SPEED_W   = 8,
    parameter int SHIFT_MPH = 75
) (
    input logic               clk,
    input logic               rst_n,
    input logic               accel,
    input logic [SPEED_W-1:0] speed,
    input logic               gear_high,
    input logic               light,
    input logic               in_chk
);
    localparam logic [SPEED_W-1:0] TOP   = {SPEED_W{1'b1}};
    localparam logic [SPEED_W-1:0] LIMIT = SPEED_W'(SHIFT_MPH);
    localparam logic [SPEED_W-1:0] ONE   = {{(SPEED_W-1){1'b0}}, 1'b1};

    // R2: phases alternate
    p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_chk |=> !in_chk);
    p_upd_to_chk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_chk |=> in_chk);
    // R3
    p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_chk && accel && speed != TOP) |=> speed == $past(speed) + ONE);
    p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_chk && accel && speed == TOP) |=> speed == TOP);
    // R4
    p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_chk && !accel && speed != '0) |=> speed == $past(speed) - ONE);
    p_sat_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_chk && !accel && speed == '0) |=> speed == '0);
    // R5
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_chk |=> $stable(speed));
    // R6 / R7
    p_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_chk && speed < LIMIT) |=> !gear_high);
    p_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_chk && speed >= LIMIT) |=> gear_high);
    // R8
    p_gear_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_chk |=> $stable(gear_high));
    // R9
    p_light_r9: assert property (@(posedge clk) disable iff (!rst_n)
        light == gear_high);
endmodule

bind gear_selector gear_selector_chk #(.SPEED_W(SPEED_W), .SHIFT_MPH(SHIFT_MPH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .accel     (accel),
    .speed     (speed),
    .gear_high (gear_high),
    .light     (light),
    .in_chk    (ctrl_chk)
);

// File: tb/gear_selector_bench.sv
module gear_selector_bench;
    localparam int W     = 8;
    localparam int SHIFT = 75;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         accel = 1'b0;
    logic [W-1:0] speed;
    logic         gear_high;
    logic         light;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    int  m_speed = 0;
    bit  m_high  = 1'b0;
    bit  m_chk   = 1'b0;

    always #5 clk = ~clk;

    gear_selector #(.SPEED_W(W), .SHIFT_MPH(SHIFT)) u_gear_selector (
        .clk       (clk),
        .rst_n     (rst_n),
        .accel     (accel),
        .speed     (speed),
        .gear_high (gear_high),
        .light     (light)
    );

    function automatic int next_speed(input int s, input bit a);
        if (a) return (s == 255) ? 255 : s + 1;
        return (s == 0) ? 0 : s - 1;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input string rs, input string rg);
        check(rs, int'(speed), m_speed);
        check(rg, int'(gear_high), int'(m_high));
        check("R9 light", int'(light), int'(m_high));
    endtask

    // called at a falling edge; crosses one rising edge; checks at next falling edge
    task automatic step(input bit a);
        string rs;
        string rg;
        accel = a;
        if (!m_chk) begin
            m_speed = next_speed(m_speed, a);
            rs = a ? "R2 R3 speed step" : "R2 R4 speed step";
            rg = "R8 gear kept";
        end else begin
            m_high = (m_speed >= SHIFT);
            rs = "R5 speed held";
            rg = m_high ? "R7 gear high" : "R6 gear low";
        end
        m_chk = !m_chk;
        @(posedge clk);
        @(negedge clk);
        check_outputs(rs, rg);
    endtask

    // update step with a, check step with opposite value (must be ignored)
    task automatic pair(input bit a);
        step(a);
        step(!a);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        accel = 1'b1;
        m_speed = 0;
        m_high  = 1'b0;
        m_chk   = 1'b0;
        @(negedge clk);
        check_outputs("R1 reset speed", "R1 reset gear");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // first edge left LOW_UPD with accel=1
        m_speed = 1;
        m_chk   = 1'b1;
        check_outputs("R1 R2 first step", "R1 gear after release");
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog actual=%0d expected<=%0d", cycles, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : stim
        void'($urandom(32'd4711));
        do_reset();
        step(1'b0); // finish the first check phase, speed 1 < 75 -> low
        // climb to 74
        repeat (73) pair(1'b1);
        check("R6 speed at 74", int'(speed), 74);
        check("R6 low at 74", int'(gear_high), 0);
        // 75 is high
        step(1'b1);
        check("R8 still low just after reaching 75", int'(gear_high), 0);
        step(1'b0);
        check("R7 high at exactly 75", int'(gear_high), 1);
        // back to 74 -> low
        pair(1'b0);
        check("R6 low again at 74", int'(gear_high), 0);
        // random walk near the shift point
        for (int i = 0; i < 600; i++) begin
            bit a;
            a = 1'($urandom_range(0, 1));
            step(a);
        end
        // climb to the top and saturate
        while (!m_chk && m_speed < 255) pair(1'b1);
        if (m_chk) step(1'b0);
        repeat (260) pair(1'b1);
        check("R3 saturate top", int'(speed), 255);
        check("R7 high at top", int'(gear_high), 1);
        // brake to the floor and saturate
        repeat (260) pair(1'b0);
        check("R4 saturate floor", int'(speed), 0);
        check("R6 low at floor", int'(gear_high), 0);
        // random mix, then a reset in mid-run
        for (int i = 0; i < 200; i++) begin
            step(1'($urandom_range(0, 3) != 0));
        end
        do_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule